// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a byte-wide flash memory with a 20-bit address. Software issues bus write cycles that each carry a command byte and an address. The decoder uses these writes to choose what a read returns: array data, the two identifier codes, or a status byte. It also turns two-write sequences into program and erase operations. A read mode stays selected until a later command replaces it. A setup byte arms a pending state, and the very next write resolves that state, either as the confirmation or as the data.

A small register array stands in for the cell array. It is divided into equal blocks. A built-in sequencer model performs the operations. A byte program takes a fixed number of cycles, and because programming can only clear bits, the stored byte becomes the old value ANDed with the new data. A block erase writes FFh into one byte of the block per cycle, and it can be suspended and resumed. Writes are sampled on the rising clock edge when `wr_en` is high. Reads are combinational from `rd_addr` and the current mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An active-low asynchronous reset selects array read mode, drops any pending setup, clears busy, suspend and both error flags, and fills the array model with FFh.
- R2: Writing FFh selects array read mode. `rd_data` then returns the stored byte at the low MEM_AW bits of `rd_addr`, and `rd_src` reads 0.
- R3: Writing 90h selects identifier mode, with `rd_src` reading 1. `rd_data` is 89h when `rd_addr` bit 0 is 0 and A2h when it is 1. The mode persists until another accepted command changes it.
- R4: Writing 70h selects status mode, with `rd_src` reading 2. The status byte carries: bit 7 set when the sequencer is ready, bit 6 set when an erase is suspended, bit 5 for the erase error, bit 4 for the program error, and zeros in bits 3 to 0.
- R5: Writing 50h clears status bits 5 and 4 and leaves the read mode unchanged.
- R6: A setup byte of 40h or 10h makes the next write a program. Its address and data are latched, `prog_start` pulses for one cycle, and PROG_CYCLES cycles later the addressed byte holds its old value AND the data.
- R7: Writing 20h and then D0h pulses `erase_start` for one cycle. The block containing the confirm address then becomes all FFh, and other blocks keep their contents.
- R8: If an erase setup is followed by any byte other than D0h, no erase starts, status bits 5 and 4 are both set, and the mode becomes status.
- R9: Starting a program or an erase switches the read mode to status in the same cycle.
- R10: With no setup pending, an undefined command byte is ignored and the read mode is unchanged. D0h with no suspended erase is also ignored.
- R11: While the sequencer is busy, only 70h and B0h (B0h only during an erase) are accepted. Every other write is ignored.
- R12: B0h during an erase pauses it, raises `ready` and sets status bit 6. While suspended, FFh, 90h, 70h and 50h are accepted and setup bytes are ignored. D0h resumes the erase, clears bit 6 and selects status mode.
- R13: `ready` is high exactly when no operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, sampled at the rising edge |
| wr_addr | input | 20 | Address latched with the write |
| wr_data | input | 8 | Command or program data byte |
| rd_addr | input | 20 | Read address |
| rd_data | output | 8 | Selected read data |
| rd_src | output | 2 | Output source: 0 array, 1 identifier, 2 status |
| ready | output | 1 | High when the sequencer is idle or suspended |
| prog_start | output | 1 | One-cycle pulse when a program starts |
| erase_start | output | 1 | One-cycle pulse when an erase starts |

## Verification
A corrupted read mode appears on `rd_src` and `rd_data` in the cycle right after the write that caused it. A lost or stray pending setup shows up only one write later: the following byte is either taken as program data or wrongly treated as a command. Faults in the sequencer state surface through `ready` and the status bits while the operation runs. Faults in the erase pointer or block selection stay hidden until array mode is selected again and the affected bytes are read, some tens of cycles after the operation started.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW          = 20,
  parameter int MEM_AW      = 6,
  parameter int BLK_AW      = 4,
  parameter int PROG_CYCLES = 8,
  parameter logic [7:0] MFR_CODE = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'hA2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [1:0]    rd_src,
  output logic          ready,
  output logic          prog_start,
  output logic          erase_start
);

  localparam int MEM_SIZE = 1 << MEM_AW;
  localparam int PCW      = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [PCW-1:0] CNT_LOAD = PCW'(PROG_CYCLES - 1);

  localparam logic [1:0] SRC_ARRAY = 2'd0;
  localparam logic [1:0] SRC_IDENT = 2'd1;
  localparam logic [1:0] SRC_STAT  = 2'd2;

  localparam logic [7:0] C_READ    = 8'hFF;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_CLEAR   = 8'h50;
  localparam logic [7:0] C_PROG_A  = 8'h40;
  localparam logic [7:0] C_PROG_B  = 8'h10;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_SUSPEND = 8'hB0;

  typedef enum logic [1:0] {P_NONE, P_PROG, P_ERASE} pend_t;

  logic [7:0]        mem [MEM_SIZE];
  logic [1:0]        mode;
  pend_t             pend;
  logic              busy, op_erase, suspended;
  logic              err_e, err_p;
  logic [MEM_AW-1:0] tgt;
  logic [7:0]        pdata;
  logic [PCW-1:0]    cnt;
  logic [BLK_AW-1:0] eptr;
  logic [7:0]        status;

  wire unused_hi = ^{wr_addr[AW-1:MEM_AW], rd_addr[AW-1:MEM_AW]};

  wire prog_done  = busy && !op_erase && (cnt == '0);
  wire erase_last = busy && op_erase && (&eptr);
  wire [MEM_AW-1:0] erase_idx = {tgt[MEM_AW-1:BLK_AW], eptr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= SRC_ARRAY;
      pend        <= P_NONE;
      busy        <= 1'b0;
      op_erase    <= 1'b0;
      suspended   <= 1'b0;
      err_e       <= 1'b0;
      err_p       <= 1'b0;
      tgt         <= '0;
      pdata       <= '0;
      cnt         <= '0;
      eptr        <= '0;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      prog_start  <= 1'b0;
      erase_start <= 1'b0;

      if (busy) begin
        if (op_erase) begin
          eptr <= eptr + 1'b1;
          if (erase_last) busy <= 1'b0;
        end else if (prog_done) begin
          busy <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end

      if (wr_en) begin
        if (pend == P_PROG) begin
          pend       <= P_NONE;
          tgt        <= wr_addr[MEM_AW-1:0];
          pdata      <= wr_data;
          cnt        <= CNT_LOAD;
          op_erase   <= 1'b0;
          busy       <= 1'b1;
          prog_start <= 1'b1;
          mode       <= SRC_STAT;
        end else if (pend == P_ERASE) begin
          pend <= P_NONE;
          mode <= SRC_STAT;
          if (wr_data == C_CONFIRM) begin
            tgt         <= wr_addr[MEM_AW-1:0];
            eptr        <= '0;
            op_erase    <= 1'b1;
            busy        <= 1'b1;
            erase_start <= 1'b1;
          end else begin
            err_e <= 1'b1;
            err_p <= 1'b1;
          end
        end else if (busy) begin
          if (wr_data == C_STATUS) mode <= SRC_STAT;
          else if (wr_data == C_SUSPEND && op_erase) begin
            busy      <= 1'b0;
            suspended <= 1'b1;
          end
        end else if (suspended) begin
          case (wr_data)
            C_READ:    mode <= SRC_ARRAY;
            C_IDENT:   mode <= SRC_IDENT;
            C_STATUS:  mode <= SRC_STAT;
            C_CLEAR:   begin err_e <= 1'b0; err_p <= 1'b0; end
            C_CONFIRM: begin
              suspended <= 1'b0;
              busy      <= 1'b1;
              mode      <= SRC_STAT;
            end
            default: ;
          endcase
        end else begin
          case (wr_data)
            C_READ:           mode <= SRC_ARRAY;
            C_IDENT:          mode <= SRC_IDENT;
            C_STATUS:         mode <= SRC_STAT;
            C_CLEAR:          begin err_e <= 1'b0; err_p <= 1'b0; end
            C_PROG_A, C_PROG_B: pend <= P_PROG;
            C_ERASE:          pend <= P_ERASE;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_SIZE; i++) mem[i] <= 8'hFF;
    end else if (busy && op_erase) begin
      mem[erase_idx] <= 8'hFF;
    end else if (prog_done) begin
      mem[tgt] <= mem[tgt] & pdata;
    end
  end

  assign status  = {~busy, suspended, err_e, err_p, 4'b0000};
  assign ready   = ~busy;
  assign rd_src  = mode;
  assign rd_data = (mode == SRC_ARRAY) ? mem[rd_addr[MEM_AW-1:0]] :
                   (mode == SRC_IDENT) ? (rd_addr[0] ? DEV_CODE : MFR_CODE) :
                   status;

  // R9
  start_to_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || erase_start) |-> (rd_src == SRC_STAT));

  // R13
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || erase_start) |-> !ready);

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && wr_en && wr_data != C_STATUS) |=> $stable(rd_src));

  // R8
  bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == P_ERASE && wr_en && wr_data != C_CONFIRM)
      |=> (status[5:4] == 2'b11 && rd_src == SRC_STAT && !erase_start));

  // R12
  suspend_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (ready && status[6]));

  // R6
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [19:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic [1:0]  rd_src;
  logic        ready, prog_start, erase_start;

  int n_cmp = 0, n_bad = 0, n_prog = 0, n_erase = 0;
  bit done = 1'b0;

  typedef struct { int sel; int exp; string tag; } item_t;
  item_t sb[$];
  event smp;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_src(rd_src), .ready(ready),
    .prog_start(prog_start), .erase_start(erase_start));

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) begin
    if (prog_start) n_prog++;
    if (erase_start) n_erase++;
  end

  initial forever begin
    @(smp);
    while (sb.size() > 0) begin
      item_t it;
      int act;
      it = sb.pop_front();
      case (it.sel)
        0: act = rd_data;
        1: act = rd_src;
        2: act = ready;
        3: act = n_prog;
        default: act = n_erase;
      endcase
      n_cmp++;
      if (act != it.exp) begin
        n_bad++;
        $display("FAIL %s: got %0h expected %0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(int sel, logic [19:0] a, int exp, string tag);
    item_t it;
    @(negedge clk);
    rd_addr = a;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    #2 -> smp;
  endtask

  task automatic cmd(logic [19:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200; i++) begin
      if (ready) return;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(1, 0, 0, "R1 reset mode");
    chk(0, 20'h00005, 8'hFF, "R1 erased model");
    chk(2, 0, 1, "R13 idle ready");

    cmd(0, 8'h90);
    chk(0, 20'h00000, 8'h89, "R3 mfr code");
    chk(0, 20'h00001, 8'hA2, "R3 dev code");
    chk(1, 0, 1, "R3 rd_src");
    cmd(0, 8'h33);
    chk(1, 0, 1, "R10 undefined ignored");
    chk(0, 20'h00001, 8'hA2, "R3 persists");

    cmd(0, 8'h70);
    chk(0, 0, 8'h80, "R4 idle status");

    cmd(20'h00005, 8'h40);
    cmd(20'h00005, 8'h5A);
    chk(1, 0, 2, "R9 status after program");
    chk(0, 0, 8'h00, "R13 busy status");
    cmd(0, 8'hFF);
    chk(1, 0, 2, "R11 busy ignores FF");
    wait_ready();
    chk(0, 0, 8'h80, "R4 ready after program");
    cmd(0, 8'hFF);
    chk(0, 20'h00005, 8'h5A, "R6 programmed byte");
    cmd(20'h00007, 8'h10);
    cmd(20'h00007, 8'h3C);
    wait_ready();
    cmd(20'h00005, 8'h40);
    cmd(20'h00005, 8'h0F);
    wait_ready();
    cmd(20'h00015, 8'h40);
    cmd(20'h00015, 8'h77);
    wait_ready();
    cmd(0, 8'hFF);
    chk(0, 20'h00007, 8'h3C, "R6 alt setup byte");
    chk(0, 20'h00005, 8'h0A, "R6 AND of old and new");
    chk(0, 20'hA0015, 8'h77, "R2 low address bits");
    chk(3, 0, 4, "R6 prog pulses");

    cmd(20'h00000, 8'h20);
    cmd(20'h00003, 8'hD0);
    chk(1, 0, 2, "R9 status after erase");
    wait_ready();
    cmd(0, 8'hFF);
    chk(0, 20'h00005, 8'hFF, "R7 block erased");
    chk(0, 20'h00007, 8'hFF, "R7 block erased");
    chk(0, 20'h00015, 8'h77, "R7 other block kept");
    chk(4, 0, 1, "R7 erase pulse");

    cmd(0, 8'h20);
    cmd(0, 8'hFF);
    chk(1, 0, 2, "R8 status mode");
    chk(0, 0, 8'hB0, "R8 error bits");
    chk(4, 0, 1, "R8 no erase");
    cmd(0, 8'h50);
    chk(1, 0, 2, "R5 mode kept");
    chk(0, 0, 8'h80, "R5 bits cleared");

    cmd(20'h00010, 8'h20);
    cmd(20'h00010, 8'hD0);
    cmd(0, 8'hB0);
    chk(0, 0, 8'hC0, "R12 suspended status");
    chk(2, 0, 1, "R12 ready while suspended");
    cmd(0, 8'h40);
    cmd(0, 8'hFF);
    chk(1, 0, 0, "R12 setup ignored, FF accepted");
    cmd(0, 8'hD0);
    chk(1, 0, 2, "R12 resume to status");
    chk(0, 0, 8'h00, "R12 resumed busy");
    wait_ready();
    cmd(0, 8'hFF);
    chk(0, 20'h00015, 8'hFF, "R7 resumed erase done");
    chk(4, 0, 2, "R7 erase pulses");

    cmd(0, 8'h20);
    cmd(0, 8'h55);
    cmd(0, 8'h20);
    do_reset();
    chk(1, 0, 0, "R1 mode after reset");
    cmd(0, 8'hD0);
    chk(1, 0, 0, "R10 lone D0 ignored");
    chk(4, 0, 2, "R1 pending dropped");
    cmd(0, 8'h70);
    chk(0, 0, 8'h80, "R1 errors cleared");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule